// File: doc/BRIEF.md
# Walking LED Alarm Indicator

This block drives a bank of indicator LEDs as a visual alarm for a countdown timer. Two conditions must both be true before anything lights: the timer reports that it has reached zero, and the user's alarm-display enable is on. Once both hold, a single lit LED walks across the bank from the lowest-indexed output to the highest. It then wraps back to the lowest and repeats for as long as both conditions stay true.

Each position is held for a fixed number of system clock cycles. An internal prescaler counts those cycles. The default of 500000 gives a 100 ms step from a 5 MHz clock. The position is tracked by a small state machine with three states. IDLE keeps every LED dark. WALK is used while a position below the last one is lit. LAST is used while the highest LED is lit. The transitions are:

- IDLE to WALK when the alarm becomes armed.
- WALK to LAST on the step that lights the highest LED.
- LAST to WALK on the step that wraps back to the lowest LED.
- WALK or LAST to IDLE as soon as the alarm is disarmed.

Top module: `led_chaser_alarm`

## Requirements
- R1: A synchronous active-high `rst` returns the block to IDLE, clears the prescaler and the position, and keeps `led` at all zeros while it is held.
- R2: The alarm is armed only when `zero_flag` and `alarm_en` are both 1. With either one at 0, `led` stays all zeros.
- R3: At the first rising edge after the alarm becomes armed in IDLE, `led` becomes 1 (only bit 0 set).
- R4: Each lit position is held for exactly `STEP_TICKS` clock cycles before the next one lights.
- R5: The walk visits bit 0, bit 1, and so on up to bit `NUM_LEDS-1`, in ascending order. Bit i drives the i-th LED of the bank.
- R6: After bit `NUM_LEDS-1` has been held for its full interval, the walk continues at bit 0 and repeats.
- R7: While the block is not in IDLE, exactly one bit of `led` is 1.
- R8: Disarming clears `led` to all zeros at the next rising edge. Re-arming afterwards always restarts at bit 0, whatever position was lit before.
- R9: A reset applied in the middle of a walk darkens `led` at that edge. Once reset is released with the alarm still armed, the walk restarts at bit 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| zero_flag | input | 1 | High while the countdown sits at zero |
| alarm_en | input | 1 | Alarm display enable |
| led | output | NUM_LEDS | One-hot walking LED drive, all zeros when idle |

## Verification
Every output change lands one rising edge after its cause: arming lights bit 0, disarming or reset darkens the bank, and releasing reset while armed lights bit 0 again. After arming, the k-th edge (counting from 1) shows bit ((k-1) / STEP_TICKS) mod NUM_LEDS. The bench drives inputs and reads `led` one nanosecond after each rising edge, so every value it compares has already settled from that edge. It computes the expected pattern from an edge count kept inside the bench itself, covering two complete walks including the wrap.

// File: rtl/chaser_pkg.sv
package chaser_pkg;

    // Walk controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // bank dark, position held at zero
        ST_WALK = 2'd1,   // some position below the last is lit
        ST_LAST = 2'd2    // highest position is lit, next step wraps
    } chase_state_t;

endpackage

// File: rtl/chaser_prescaler.sv
module chaser_prescaler #(
    parameter int STEP_TICKS = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (STEP_TICKS > 2) ? $clog2(STEP_TICKS) : 1;
    localparam logic [CNT_W-1:0] TERM = CNT_W'(STEP_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == TERM) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == TERM);

    // R4: the interval counter never passes its terminal count
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= TERM);

    // R4: a stopped prescaler restarts its interval from zero
    assert_restart_from_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);

endmodule

// File: rtl/chaser_position.sv
module chaser_position #(
    parameter int NUM_LEDS = 14
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic                        advance,
    output logic [$clog2(NUM_LEDS)-1:0] pos
);
    localparam int POS_W = $clog2(NUM_LEDS);
    localparam logic [POS_W-1:0] TOP = POS_W'(NUM_LEDS - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos <= '0;
        end else if (advance) begin
            if (pos == TOP) begin
                pos <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // R5: a step moves exactly one place upward
    assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear && pos != TOP) |=> pos == $past(pos) + 1'b1);

    // R6: stepping from the highest place returns to the lowest
    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear && pos == TOP) |=> pos == '0);

    // R4: without a step the position holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clear) |=> $stable(pos));

endmodule

// File: rtl/chaser_onehot.sv
module chaser_onehot #(
    parameter int NUM_LEDS = 14
) (
    input  logic                        lit,
    input  logic [$clog2(NUM_LEDS)-1:0] pos,
    output logic [NUM_LEDS-1:0]         bank
);
    localparam int POS_W = $clog2(NUM_LEDS);

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_bit
        assign bank[i] = lit && (pos == POS_W'(i));
    end

endmodule

// File: rtl/led_chaser_alarm.sv
module led_chaser_alarm #(
    parameter int NUM_LEDS   = 14,
    parameter int STEP_TICKS = 500000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                zero_flag,
    input  logic                alarm_en,
    output logic [NUM_LEDS-1:0] led
);
    import chaser_pkg::*;

    localparam int POS_W = $clog2(NUM_LEDS);
    localparam logic [POS_W-1:0] PENULT = POS_W'(NUM_LEDS - 2);

    chase_state_t     state, state_nx;
    logic             armed;
    logic             run;
    logic             tick;
    logic             lit;
    logic [POS_W-1:0] pos;

    assign armed = zero_flag && alarm_en;
    assign run   = armed && (state != ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (armed) state_nx = ST_WALK;
            end
            ST_WALK: begin
                if (!armed)                        state_nx = ST_IDLE;
                else if (tick && pos == PENULT)    state_nx = ST_LAST;
            end
            ST_LAST: begin
                if (!armed)     state_nx = ST_IDLE;
                else if (tick)  state_nx = ST_WALK;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_IDLE: lit = 1'b0;
            ST_WALK: lit = 1'b1;
            ST_LAST: lit = 1'b1;
            default: lit = 1'b0;
        endcase
    end

    chaser_prescaler #(.STEP_TICKS(STEP_TICKS)) u_prescaler (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    chaser_position #(.NUM_LEDS(NUM_LEDS)) u_position (
        .clk     (clk),
        .rst     (rst),
        .clear   (!run),
        .advance (tick),
        .pos     (pos)
    );

    chaser_onehot #(.NUM_LEDS(NUM_LEDS)) u_onehot (
        .lit  (lit),
        .pos  (pos),
        .bank (led)
    );

    // R7: a single LED is lit whenever the walk is active
    assert_single_lit_R7: assert property (@(posedge clk) disable iff (rst)
        state != ST_IDLE |-> $onehot(led));

    // R2 / R8: disarming darkens the bank at the next edge
    assert_dark_after_disarm_R8: assert property (@(posedge clk) disable iff (rst)
        !armed |=> led == '0);

    // R3: arming from idle lights the lowest LED first
    assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && armed) |=> led == NUM_LEDS'(1));

    // R6: the LAST state always shows the highest LED
    assert_last_top_R6: assert property (@(posedge clk) disable iff (rst)
        state == ST_LAST |-> led[NUM_LEDS-1]);

endmodule

// File: tb/test_led_chaser_alarm.sv
`timescale 1ns/1ps
module test_led_chaser_alarm;

    localparam int N = 14;
    localparam int T = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         zero_flag = 1'b0;
    logic         alarm_en = 1'b0;
    logic [N-1:0] led;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    led_chaser_alarm #(.NUM_LEDS(N), .STEP_TICKS(T)) i_led_chaser_alarm (
        .clk       (clk),
        .rst       (rst),
        .zero_flag (zero_flag),
        .alarm_en  (alarm_en),
        .led       (led)
    );

    // Advance n rising edges, then settle 1 ns past the last one
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [N-1:0] exp);
        checks++;
        if (led !== exp) begin
            errors++;
            $display("FAIL %s: led=%h expected=%h at %0t", req, led, exp, $time);
        end
    endtask

    // Expected bank k edges after arming (k >= 1)
    function automatic logic [N-1:0] model(input int k);
        return N'(1) << (((k - 1) / T) % N);
    endfunction

    task automatic t_reset();
        rst = 1'b1; zero_flag = 1'b0; alarm_en = 1'b0;
        edges(3);
        check("R1 reset dark", '0);
        rst = 1'b0;
        edges(2);
        check("R1 idle after reset", '0);
    endtask

    task automatic t_partial_arm();
        zero_flag = 1'b1; alarm_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            edges(1);
            check("R2 zero only", '0);
        end
        zero_flag = 1'b0; alarm_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            edges(1);
            check("R2 enable only", '0);
        end
        alarm_en = 1'b0;
        edges(1);
    endtask

    task automatic t_full_walk();
        zero_flag = 1'b1; alarm_en = 1'b1;
        edges(1);
        check("R3 first lit", N'(1));
        for (int k = 2; k <= 2 * N * T + 2; k++) begin
            edges(1);
            if (k == N * T + 1) check("R6 wrap", N'(1));
            else if (((k - 1) % T) == 0) check("R5 order", model(k));
            else check("R4 dwell", model(k));
            checks++;
            if ($countones(led) != 1) begin
                errors++;
                $display("FAIL R7: led=%h expected=one bit set", led);
            end
        end
        zero_flag = 1'b0;
        edges(1);
        check("R8 dark after disarm", '0);
    endtask

    task automatic t_disarm_midway();
        zero_flag = 1'b1; alarm_en = 1'b1;
        edges(10);
        check("R5 mid walk", model(10));
        alarm_en = 1'b0;
        edges(1);
        check("R8 disarm clears", '0);
        alarm_en = 1'b1;
        edges(1);
        check("R8 rearm restarts", N'(1));
        edges(T);
        check("R8 step after rearm", N'(2));
    endtask

    task automatic t_reset_midway();
        edges(7);
        rst = 1'b1;
        edges(1);
        check("R9 reset darkens", '0);
        rst = 1'b0;
        edges(1);
        check("R9 restart at bit 0", N'(1));
        zero_flag = 1'b0; alarm_en = 1'b0;
        edges(1);
        check("R2 dark at end", '0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_partial_arm();
        t_full_walk();
        t_disarm_midway();
        t_reset_midway();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule